// File: doc/BRIEF.md
# Write-Back Write-Allocate Cache Controller

This block is the miss-handling controller of a direct-mapped cache. The cache uses write-back, so memory is updated only when a block is replaced. It also allocates a block on every write miss. Each frame holds one data word, a tag, a valid flag and a dirty flag. The CPU side presents one request at a time and holds it until `cpu_ready` is returned.

A hit is decided in the same cycle the request is presented and completes in that cycle. A hit never touches memory. A write hit updates the stored word and marks the frame dirty. On a miss the controller looks at the victim frame. A clean or empty victim is overwritten by a single refill from memory. A dirty victim is first copied back to memory at the address rebuilt from its stored tag and the current index, and only then is the missing word fetched. After the refill the controller replays the request as a hit. A replayed write therefore dirties the freshly loaded frame, and a replayed read leaves it clean.

The memory side uses a request/acknowledge handshake. The controller holds `mem_req` with a stable address, direction and write data until memory answers with a one-cycle `mem_ack`. Read data is taken in the acknowledge cycle.

Top module: `wbwa_cache_ctrl`

## Requirements
- R1: After reset every frame is invalid and clean. With no request pending, `cpu_ready` and `mem_req` are low, and the first access to any address misses and causes exactly one memory read and no memory write.
- R2: A read whose index selects a valid frame with a matching tag raises `cpu_ready` in the cycle the request is presented. It returns the stored word on `cpu_rdata` and performs no memory transfer.
- R3: A write hit raises `cpu_ready` in the cycle it is presented and performs no memory transfer. A later read of the same address returns the written word.
- R4: A miss whose victim frame is valid and dirty first issues a memory write (`mem_we`=1) of the victim's word. That write goes to address {stored tag, index}, where the index is the low INDEX_W bits of the address. The controller then issues one memory read of the requested address, so a dirty miss costs two transfers.
- R5: A miss whose victim frame is clean or invalid issues exactly one memory read, at the requested address, and no memory write.
- R6: A write miss loads the block and then applies the write as a hit. The frame is then dirty, so evicting it later writes the new word back to memory.
- R7: A read miss leaves the refilled frame clean, so evicting it later performs no memory write.
- R8: While the CPU holds its request, `cpu_ready` stays low from the miss until the replay. The replayed access completes in the cycle after the refill acknowledge. With memory latency L, a clean miss completes L+1 cycles after presentation and a dirty miss 2L+1 cycles after presentation.
- R9: Once `mem_req` is raised it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low INDEX_W bits form the index, the rest the tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ready` is high on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Refill data, taken in the acknowledge cycle |
| mem_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The bench builds the controller with a 16-bit word address, 32-bit data and 8 frames (INDEX_W = 3). It attaches a memory model that acknowledges each request after a fixed latency of 4 cycles. Because there are only 8 frames and the random addresses use just four tag values, the same index is reused often. This produces frequent conflict evictions of both clean and dirty victims, write misses that are evicted again later, and long runs of hits. The 4-cycle latency separates the expected completion times of hits (0 cycles), clean misses (5 cycles) and dirty misses (9 cycles), so each path can be identified by its timing.

// File: rtl/wbwa_cache_pkg.sv
package wbwa_cache_pkg;
   typedef enum logic [1:0] {
      ST_LOOKUP = 2'd0,
      ST_EVICT  = 2'd1,
      ST_FILL   = 2'd2
   } ctrl_state_e;
endpackage

// File: rtl/wbwa_tag_store.sv
module wbwa_tag_store #(
   parameter int SETS    = 8,
   parameter int INDEX_W = 3,
   parameter int TAG_W   = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] idx,
   input  logic               fill_en,
   input  logic [TAG_W-1:0]   fill_tag,
   input  logic               mark_dirty,
   output logic               rd_valid,
   output logic               rd_dirty,
   output logic [TAG_W-1:0]   rd_tag
);
   logic             vld [SETS];
   logic             drt [SETS];
   logic [TAG_W-1:0] tg  [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_frame
      logic sel;
      assign sel = (idx == INDEX_W'(s));

      // flags are reset; a refill makes the frame valid and clean
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld[s] <= 1'b0;
            drt[s] <= 1'b0;
         end else if (sel) begin
            if (fill_en) begin
               vld[s] <= 1'b1;
               drt[s] <= 1'b0;
            end else if (mark_dirty) begin
               drt[s] <= 1'b1;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (sel && fill_en) tg[s] <= fill_tag;
      end
   end

   assign rd_valid = vld[idx];
   assign rd_dirty = drt[idx];
   assign rd_tag   = tg[idx];
endmodule

// File: rtl/wbwa_data_store.sv
module wbwa_data_store #(
   parameter int SETS    = 8,
   parameter int INDEX_W = 3,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic [INDEX_W-1:0] idx,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data
);
   logic [DATA_W-1:0] words [SETS];

   always_ff @(posedge clk) begin
      if (wr_en) words[idx] <= wr_data;
   end

   assign rd_data = words[idx];
endmodule

// File: rtl/wbwa_ctrl_fsm.sv
module wbwa_ctrl_fsm
   import wbwa_cache_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cpu_req,
   input  logic        cpu_we,
   input  logic        hit,
   input  logic        victim_dirty,
   input  logic        mem_ack,
   output ctrl_state_e state,
   output logic        cpu_ready,
   output logic        mem_req,
   output logic        mem_we,
   output logic        fill_en,
   output logic        hit_write
);
   ctrl_state_e nxt;

   always_comb begin
      nxt       = state;
      cpu_ready = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      fill_en   = 1'b0;
      hit_write = 1'b0;
      unique case (state)
         ST_LOOKUP: begin
            if (cpu_req && hit) begin
               cpu_ready = 1'b1;
               hit_write = cpu_we;
            end else if (cpu_req) begin
               nxt = victim_dirty ? ST_EVICT : ST_FILL;
            end
         end
         ST_EVICT: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            if (mem_ack) nxt = ST_FILL;
         end
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               fill_en = 1'b1;
               nxt     = ST_LOOKUP;
            end
         end
         default: nxt = ST_LOOKUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_LOOKUP;
      else        state <= nxt;
   end
endmodule

// File: rtl/wbwa_cache_ctrl.sv
module wbwa_cache_ctrl
   import wbwa_cache_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   localparam int SETS  = 1 << INDEX_W;
   localparam int TAG_W = ADDR_W - INDEX_W;

   logic [INDEX_W-1:0] idx;
   logic [TAG_W-1:0]   req_tag;
   logic               rd_valid, rd_dirty;
   logic [TAG_W-1:0]   rd_tag;
   logic [DATA_W-1:0]  rd_data;
   logic               hit, victim_dirty, fill_en, hit_write;
   ctrl_state_e        state;

   assign idx     = cpu_addr[INDEX_W-1:0];
   assign req_tag = cpu_addr[ADDR_W-1:INDEX_W];

   wbwa_tag_store #(.SETS(SETS), .INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(idx), .fill_en(fill_en),
      .fill_tag(req_tag), .mark_dirty(hit_write),
      .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag)
   );

   wbwa_data_store #(.SETS(SETS), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_data (
      .clk(clk), .idx(idx), .wr_en(fill_en | hit_write),
      .wr_data(fill_en ? mem_rdata : cpu_wdata), .rd_data(rd_data)
   );

   assign hit          = rd_valid && (rd_tag == req_tag);
   assign victim_dirty = rd_valid && rd_dirty;

   wbwa_ctrl_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .hit(hit), .victim_dirty(victim_dirty), .mem_ack(mem_ack),
      .state(state), .cpu_ready(cpu_ready), .mem_req(mem_req),
      .mem_we(mem_we), .fill_en(fill_en), .hit_write(hit_write)
   );

   // eviction address comes from the stored tag, not from the CPU tag
   assign mem_addr  = (state == ST_EVICT) ? {rd_tag, idx} : cpu_addr;
   assign mem_wdata = rd_data;
   assign cpu_rdata = rd_data;
endmodule

// File: rtl/wbwa_cache_checker.sv
module wbwa_cache_checker #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 32,
   parameter int INDEX_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !mem_req);

   assert_ready_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   assert_wb_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[INDEX_W-1:0] == cpu_addr[INDEX_W-1:0]));

   assert_wb_then_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

   assert_fill_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr == cpu_addr));

   assert_replay_after_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ack) |=> cpu_ready);

   assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   assert_wdata_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));
endmodule

bind wbwa_cache_ctrl wbwa_cache_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
   .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/tb_wbwa_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wbwa_cache_ctrl;
   localparam int ADDR_W  = 16;
   localparam int DATA_W  = 32;
   localparam int INDEX_W = 3;
   localparam int SETS    = 1 << INDEX_W;
   localparam int TAG_W   = ADDR_W - INDEX_W;
   localparam int LAT     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0;
   logic [DATA_W-1:0] cpu_rdata;
   logic              cpu_ready;
   logic              mem_req, mem_we, mem_ack;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   wbwa_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) dut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   function automatic logic [DATA_W-1:0] init_word(input int a);
      return (32'(a) * 32'h9E37_79B1) ^ 32'hA5A5_0000;
   endfunction

   // fixed-latency memory model
   logic [DATA_W-1:0] mem_model [1 << ADDR_W];
   int                lat_cnt = 0;
   int                n_wr = 0, n_rd = 0;
   logic [ADDR_W-1:0] wb_addr;
   logic [DATA_W-1:0] wb_data;

   assign mem_ack   = mem_req && (lat_cnt == LAT - 1);
   assign mem_rdata = mem_model[mem_addr];

   always @(posedge clk) begin
      if (mem_ack) begin
         lat_cnt <= 0;
         if (mem_we) begin
            mem_model[mem_addr] <= mem_wdata;
            n_wr    <= n_wr + 1;
            wb_addr <= mem_addr;
            wb_data <= mem_wdata;
         end else begin
            n_rd <= n_rd + 1;
         end
      end else if (mem_req) begin
         lat_cnt <= lat_cnt + 1;
      end
   end

   // bench reference model
   logic              m_vld [SETS];
   logic              m_drt [SETS];
   logic [TAG_W-1:0]  m_tag [SETS];
   logic [DATA_W-1:0] m_dat [SETS];
   logic [DATA_W-1:0] ref_mem [1 << ADDR_W];

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [ADDR_W-1:0] addr,
                         input logic [DATA_W-1:0] wd, input string req);
      int                idx;
      logic [TAG_W-1:0]  tg;
      bit                hit, exp_wb;
      logic [ADDR_W-1:0] exp_wb_addr;
      logic [DATA_W-1:0] exp_wb_data, exp_rd;
      int                exp_cyc, cyc, wr0, rd0;
      idx = int'(addr[INDEX_W-1:0]);
      tg  = addr[ADDR_W-1:INDEX_W];
      hit = m_vld[idx] && (m_tag[idx] == tg);
      exp_wb = !hit && m_vld[idx] && m_drt[idx];
      exp_wb_addr = {m_tag[idx], addr[INDEX_W-1:0]};
      exp_wb_data = m_dat[idx];
      if (!hit) begin
         if (exp_wb) ref_mem[exp_wb_addr] = exp_wb_data;
         m_dat[idx] = ref_mem[addr];
         m_vld[idx] = 1'b1;
         m_drt[idx] = 1'b0;
         m_tag[idx] = tg;
      end
      if (we) begin
         m_dat[idx] = wd;
         m_drt[idx] = 1'b1;
      end
      exp_rd  = m_dat[idx];
      exp_cyc = hit ? 0 : (exp_wb ? 2 * LAT + 1 : LAT + 1);
      wr0 = n_wr;
      rd0 = n_rd;
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = addr;
      cpu_wdata = wd;
      #1;
      cyc = 0;
      while (!cpu_ready && cyc < 40) begin
         @(negedge clk);
         #1;
         cyc++;
      end
      chk(cyc == exp_cyc, req, "completion cycles", cyc, exp_cyc);
      if (!we) chk(cpu_rdata == exp_rd, req, "read data", cpu_rdata, exp_rd);
      chk((n_wr - wr0) == (exp_wb ? 1 : 0), req, "memory writes", n_wr - wr0, exp_wb ? 1 : 0);
      chk((n_rd - rd0) == (hit ? 0 : 1), req, "memory reads", n_rd - rd0, hit ? 0 : 1);
      if (exp_wb) begin
         chk(wb_addr == exp_wb_addr, req, "write-back address", wb_addr, exp_wb_addr);
         chk(wb_data == exp_wb_data, req, "write-back data", wb_data, exp_wb_data);
      end
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < (1 << ADDR_W); a++) begin
         mem_model[a] = init_word(a);
         ref_mem[a]   = init_word(a);
      end
      for (int s = 0; s < SETS; s++) begin
         m_vld[s] = 1'b0;
         m_drt[s] = 1'b0;
         m_tag[s] = '0;
         m_dat[s] = '0;
      end
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(cpu_ready == 1'b0, "R1", "ready after reset", cpu_ready, 0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
      @(negedge clk);

      // directed corner cases
      access(1'b0, 16'h0005, '0, "R1");           // cold read miss
      access(1'b0, 16'h0005, '0, "R2");           // read hit
      access(1'b1, 16'h0005, 32'hDEAD_0001, "R3");  // write hit
      access(1'b0, 16'h0005, '0, "R3");           // read back the written word
      access(1'b0, 16'h0015, '0, "R4");           // dirty victim evicted
      access(1'b1, 16'h0032, 32'hBEEF_0002, "R6");  // write miss
      access(1'b0, 16'h00A2, '0, "R6");           // evicts the written word
      access(1'b0, 16'h0007, '0, "R5");           // clean cold fill
      access(1'b0, 16'h0017, '0, "R7");           // read-filled victim, no write-back
      access(1'b1, 16'h0027, 32'h1234_5678, "R8");  // write miss on clean victim
      access(1'b0, 16'h0037, '0, "R8");           // dirty miss, long stall

      // constrained random traffic on few tags to force conflicts
      for (int i = 0; i < 400; i++) begin
         bit                we;
         logic [ADDR_W-1:0] a;
         int                ix;
         string             rq;
         we = 1'($urandom_range(0, 1));
         a  = {TAG_W'($urandom_range(0, 3)), INDEX_W'($urandom_range(0, SETS - 1))};
         ix = int'(a[INDEX_W-1:0]);
         if (m_vld[ix] && m_tag[ix] == a[ADDR_W-1:INDEX_W]) rq = we ? "R3" : "R2";
         else if (m_vld[ix] && m_drt[ix]) rq = "R4";
         else rq = we ? "R6" : "R5";
         access(we, a, $urandom, rq);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule